// File: doc/BRIEF.md
# Two-Level Adaptive Branch Predictor

This unit predicts direction and target for a simple fetch stage. A shift register of recent resolved outcomes is XORed with low fetch-address bits to select one 2-bit confidence counter. A small direct-mapped target table supplies the redirect address. A circular return-address stack supplies targets for returns. The fetch stage presents a PC every cycle and reads the prediction combinationally in the same cycle. It also reads the current history value, which it keeps as a checkpoint with the branch.

When a branch resolves, the back end presents one update. The update carries the PC, the outcome, the actual target, a mispredict flag and the checkpoint returned at predict time. A mispredict rebuilds the history from that checkpoint. Call and return hints maintain the stack. All lookups are combinational and every update is accepted in the cycle it is valid. The block never back-pressures, so it has no ready outputs, and the valid inputs are single-cycle strobes.

The counters use a Gray-coded order: 00 strong not-taken, 01 weak not-taken, 11 weak taken, 10 strong taken. Each step along this order changes one bit.

Top module: `bpred_top`

## Requirements
- R1: After reset the history is 0, every counter is 01 (weak not-taken) and every target entry is invalid. Any non-return lookup therefore gives pred_taken=0, pred_hit=0 and pred_target=pred_pc+4.
- R2: The counter index is pred_hist XOR pred_pc[7:2]. pred_taken for a non-return lookup is 1 exactly when the selected counter is 11 or 10.
- R3: An update steps the counter at index upd_hist XOR upd_pc[7:2] one place along 00,01,11,10. Taken moves toward 10 and not-taken moves toward 00, and each saturates at its end.
- R4: An update with upd_mispred=0 shifts upd_taken into bit 0 of the history, and the old bits move up one place. Without an update the history holds.
- R5: An update with upd_mispred=1 sets the history to {upd_hist[4:0], upd_taken}.
- R6: A taken update writes the target entry at upd_pc[5:2] with tag upd_pc[13:6] and target upd_target. A not-taken update leaves the table unchanged. A non-return lookup hits only on a valid entry with a matching tag. On a hit pred_target is the stored target, otherwise it is pred_pc+4.
- R7: While ret_valid is 1, pred_taken=1, pred_hit=1 and pred_target is the top of the return stack. The stack pops at the clock edge.
- R8: call_valid pushes call_ret_addr. A push to a full stack of depth 4 overwrites the oldest entry.
- R9: Popping the last valid entry leaves it as the top. Further pops on an empty stack change nothing and keep returning it. After reset the top is 0.
- R10: call_valid and ret_valid together replace the top entry with call_ret_addr. If the stack is empty, the entry count becomes 1.
- R11: A lookup in the same cycle as an update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | 32 | Fetch PC to predict |
| pred_taken | output | 1 | Predicted taken |
| pred_hit | output | 1 | Target is valid (table hit or return) |
| pred_target | output | 32 | Predicted next PC |
| pred_hist | output | 6 | Current history, kept as checkpoint |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved target |
| upd_mispred | input | 1 | Branch was mispredicted |
| upd_hist | input | 6 | Checkpoint returned at predict time |
| call_valid | input | 1 | Call hint, push |
| call_ret_addr | input | 32 | Return address to push |
| ret_valid | input | 1 | Return hint, predict from stack and pop |

## Verification
The bench walks one counter through both saturation ends. A binary-coded counter, or one that fails to saturate, would flip the predicted direction at the wrong step. It aliases two PCs onto one target entry and sends a not-taken update for a trained PC. A missing tag compare would then produce false hits, and writing on not-taken would corrupt the target. It also overfills and overdrains the return stack and issues a call and a return together. A wrong wrap or underflow rule would return a stale or zero address. Random mispredict traffic shows whether the history is rebuilt from the checkpoint rather than from the live register.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b11;
  localparam ctr_t CTR_ST  = 2'b10;

  // One step along the Gray-ordered confidence chain.
  function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
    ctr_t n;
    case (c)
      CTR_SNT: n = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: n = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  n = taken ? CTR_ST  : CTR_WNT;
      default: n = taken ? CTR_ST  : CTR_WT;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/bpred_pht.sv
module bpred_pht
  import bpred_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int N = 1 << IDX_W;

  ctr_t ctr [N];

  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctr[e] <= CTR_WNT;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        ctr[e] <= ctr_next(ctr[e], wr_taken);
      end
    end
  end

  // Upper bit set means a taken state (11 or 10).
  assign rd_taken = ctr[rd_idx][1];
endmodule

// File: rtl/bpred_btb.sv
module bpred_btb #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PC_W-1:0]  rd_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0]     vld;
  logic [TAG_W-1:0] tags [N];
  logic [PC_W-1:0]  tgts [N];

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[e] <= 1'b0;
      end else if (sel) begin
        vld[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tags[e] <= wr_tag;
        tgts[e] <= wr_target;
      end
    end
  end

  assign rd_hit    = vld[rd_idx] && (tags[rd_idx] == rd_tag);
  assign rd_target = tgts[rd_idx];
endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [PC_W-1:0]            push_addr,
  output logic [PC_W-1:0]            top,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] ptr, ptr_nxt, ptr_prv;
  logic [CNT_W-1:0] cnt;

  assign ptr_nxt = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign ptr_prv = (ptr == '0) ? PTR_W'(DEPTH - 1) : ptr - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push && pop) begin
      mem[ptr] <= push_addr;
      if (cnt == '0) cnt <= CNT_W'(1);
    end else if (push) begin
      mem[ptr_nxt] <= push_addr;
      ptr          <= ptr_nxt;
      if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
    end else if (pop) begin
      // The last valid entry stays addressed once the stack drains.
      if (cnt > CNT_W'(1)) ptr <= ptr_prv;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign top   = mem[ptr];
  assign count = cnt;
endmodule

// File: rtl/bpred_top.sv
module bpred_top #(
  parameter int PC_W      = 32,
  parameter int ALIGN     = 2,
  parameter int HIST_W    = 6,
  parameter int BTB_IDX_W = 4,
  parameter int TAG_W     = 8,
  parameter int RAS_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic              pred_hit,
  output logic [PC_W-1:0]   pred_target,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [PC_W-1:0]   upd_target,
  input  logic              upd_mispred,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              call_valid,
  input  logic [PC_W-1:0]   call_ret_addr,
  input  logic              ret_valid
);
  localparam int CNT_W = $clog2(RAS_DEPTH + 1);
  localparam int TAG_LSB = ALIGN + BTB_IDX_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN;

  logic [HIST_W-1:0] ghr;
  logic              pht_taken;
  logic              btb_hit;
  logic [PC_W-1:0]   btb_tgt;
  logic [PC_W-1:0]   ras_top;
  logic [CNT_W-1:0]  ras_cnt;
  logic [HIST_W-1:0] rd_idx, wr_idx;
  logic              unused_upd_pc;

  assign rd_idx = ghr ^ pred_pc[ALIGN +: HIST_W];
  assign wr_idx = upd_hist ^ upd_pc[ALIGN +: HIST_W];
  assign unused_upd_pc = ^upd_pc;

  bpred_pht #(.IDX_W(HIST_W)) pht_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_taken (pht_taken),
    .wr_en    (upd_valid),
    .wr_idx   (wr_idx),
    .wr_taken (upd_taken)
  );

  bpred_btb #(.PC_W(PC_W), .IDX_W(BTB_IDX_W), .TAG_W(TAG_W)) btb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (pred_pc[ALIGN +: BTB_IDX_W]),
    .rd_tag    (pred_pc[TAG_LSB +: TAG_W]),
    .rd_hit    (btb_hit),
    .rd_target (btb_tgt),
    .wr_en     (upd_valid && upd_taken),
    .wr_idx    (upd_pc[ALIGN +: BTB_IDX_W]),
    .wr_tag    (upd_pc[TAG_LSB +: TAG_W]),
    .wr_target (upd_target)
  );

  bpred_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) ras_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (call_valid),
    .pop       (ret_valid),
    .push_addr (call_ret_addr),
    .top       (ras_top),
    .count     (ras_cnt)
  );

  // Non-speculative history; a mispredict rebuilds from the checkpoint.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghr <= '0;
    end else if (upd_valid) begin
      if (upd_mispred) ghr <= {upd_hist[HIST_W-2:0], upd_taken};
      else             ghr <= {ghr[HIST_W-2:0], upd_taken};
    end
  end

  always_comb begin
    if (ret_valid) begin
      pred_taken  = 1'b1;
      pred_hit    = 1'b1;
      pred_target = ras_top;
    end else begin
      pred_taken  = pht_taken;
      pred_hit    = btb_hit;
      pred_target = btb_hit ? btb_tgt : pred_pc + STEP;
    end
  end

  assign pred_hist = ghr;
endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
  parameter int HIST_W    = 6,
  parameter int RAS_DEPTH = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           upd_valid,
  input logic                           upd_taken,
  input logic                           upd_mispred,
  input logic [HIST_W-1:0]              upd_hist,
  input logic                           call_valid,
  input logic                           ret_valid,
  input logic                           pred_taken,
  input logic                           pred_hit,
  input logic [HIST_W-1:0]              pred_hist,
  input logic [$clog2(RAS_DEPTH+1)-1:0] ras_cnt
);
  localparam int CNT_W = $clog2(RAS_DEPTH + 1);

  logic unused_hist_msb;
  assign unused_hist_msb = upd_hist[HIST_W-1];

  // R4
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_mispred |=>
      pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)});

  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_hist));

  // R5
  hist_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_mispred |=>
      pred_hist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)});

  // R7
  ret_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> pred_taken && pred_hit);

  // R8
  ras_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_cnt <= CNT_W'(RAS_DEPTH));

  // R8
  ras_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && !ret_valid |=>
      ras_cnt == (($past(ras_cnt) == CNT_W'(RAS_DEPTH)) ? CNT_W'(RAS_DEPTH)
                                                        : $past(ras_cnt) + 1'b1));

  // R9
  ras_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !call_valid && ras_cnt == '0 |=> ras_cnt == '0);

  // R10
  ras_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && ret_valid |=> ras_cnt != '0);
endmodule

bind bpred_top bpred_chk #(.HIST_W(HIST_W), .RAS_DEPTH(RAS_DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_valid   (upd_valid),
  .upd_taken   (upd_taken),
  .upd_mispred (upd_mispred),
  .upd_hist    (upd_hist),
  .call_valid  (call_valid),
  .ret_valid   (ret_valid),
  .pred_taken  (pred_taken),
  .pred_hit    (pred_hit),
  .pred_hist   (pred_hist),
  .ras_cnt     (ras_cnt)
);

// File: tb/bpred_top_tb_top.sv
module bpred_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken, pred_hit;
  logic [31:0] pred_target;
  logic [5:0]  pred_hist;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic        upd_mispred = 1'b0;
  logic [5:0]  upd_hist = '0;
  logic        call_valid = 1'b0;
  logic [31:0] call_ret_addr = '0;
  logic        ret_valid = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference state: strengths 0..3 (SNT,WNT,WT,ST), plain arrays and a queue.
  int          m_pht [64];
  bit          m_v   [16];
  int unsigned m_tag [16];
  bit [31:0]   m_tgt [16];
  int unsigned m_ghr;
  bit [31:0]   rq [$];
  bit [31:0]   rlast;

  always #2 clk = ~clk;

  bpred_top dut_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_hit(pred_hit), .pred_target(pred_target), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_mispred(upd_mispred), .upd_hist(upd_hist),
    .call_valid(call_valid), .call_ret_addr(call_ret_addr), .ret_valid(ret_valid)
  );

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_pht[i] = 1;
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = '0;
    end
    m_ghr = 0;
    rq.delete();
    rlast = '0;
  endtask

  task automatic compare(input string tag);
    int unsigned idx, bi, tg;
    bit e_tk, e_hit;
    bit [31:0] e_tgt;
    idx = (m_ghr ^ (pred_pc >> 2)) & 63;
    bi  = (pred_pc >> 2) & 15;
    tg  = (pred_pc >> 6) & 255;
    if (ret_valid) begin
      e_tk = 1; e_hit = 1;
      e_tgt = (rq.size() > 0) ? rq[rq.size()-1] : rlast;
    end else begin
      e_tk  = (m_pht[idx] >= 2);
      e_hit = m_v[bi] && (m_tag[bi] == tg);
      e_tgt = e_hit ? m_tgt[bi] : pred_pc + 32'd4;
    end
    checks++;
    if (pred_taken !== e_tk || pred_hit !== e_hit || pred_target !== e_tgt ||
        pred_hist !== 6'(m_ghr)) begin
      errors++;
      $display("FAIL %s: taken/hit/target/hist actual %b/%b/%h/%h expected %b/%b/%h/%h",
               tag, pred_taken, pred_hit, pred_target, pred_hist,
               e_tk, e_hit, e_tgt, 6'(m_ghr));
    end
  endtask

  task automatic model_update();
    int unsigned wi, bi;
    if (call_valid && ret_valid) begin
      if (rq.size() > 0) rq[rq.size()-1] = call_ret_addr;
      else rq.push_back(call_ret_addr);
    end else if (call_valid) begin
      rq.push_back(call_ret_addr);
      if (rq.size() > 4) void'(rq.pop_front());
    end else if (ret_valid) begin
      if (rq.size() > 0) rlast = rq.pop_back();
    end
    if (upd_valid) begin
      wi = (upd_hist ^ (upd_pc >> 2)) & 63;
      if (upd_taken && m_pht[wi] < 3) m_pht[wi]++;
      if (!upd_taken && m_pht[wi] > 0) m_pht[wi]--;
      if (upd_taken) begin
        bi = (upd_pc >> 2) & 15;
        m_v[bi] = 1; m_tag[bi] = (upd_pc >> 6) & 255; m_tgt[bi] = upd_target;
      end
      m_ghr = (((upd_mispred ? int'(upd_hist) : m_ghr) << 1) | upd_taken) & 63;
    end
  endtask

  // Called at a falling edge with inputs set; compares, then clocks.
  task automatic cycle(input string tag);
    #1;
    compare(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic quiet();
    upd_valid = 0; upd_taken = 0; upd_mispred = 0; call_valid = 0; ret_valid = 0;
  endtask

  task automatic upd(input bit [31:0] pc, input bit tk, input bit [31:0] tgt,
                     input bit mis, input bit [5:0] h);
    upd_valid = 1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    upd_mispred = mis; upd_hist = h;
  endtask

  task automatic scalar_check(input string tag, input bit ok, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    bit [31:0] a_pc, alias_pc;
    bit [4:0] outs;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    #1;
    scalar_check("R1 hist", pred_hist == 6'd0, pred_hist, 0);
    for (int i = 0; i < 6; i++) begin
      pred_pc = $urandom_range(0, 4095) << 2;
      cycle("R1");
    end

    // R3: walk counter 5 through both ends; lookup aimed at the same index (R2)
    outs = 5'b0;
    for (int i = 0; i < 12; i++) begin
      bit t;
      t = (i < 5) || (i == 11);
      upd(32'h14, t, 32'h0000_0800, 1'b0, 6'd0);
      pred_pc = ((m_ghr ^ 5) & 63) << 2;
      cycle("R3");
    end
    quiet();
    pred_pc = ((m_ghr ^ 5) & 63) << 2;
    cycle("R2");

    // R6: target table allocate, alias miss, not-taken keeps entry
    a_pc = 32'h0000_2A44;
    alias_pc = a_pc ^ 32'h40;
    upd(a_pc, 1'b1, 32'h0000_5000, 1'b0, pred_hist);
    pred_pc = a_pc;
    cycle("R11");
    quiet();
    pred_pc = a_pc;      cycle("R6");
    pred_pc = alias_pc;  cycle("R6");
    upd(a_pc, 1'b0, 32'h0000_6000, 1'b0, pred_hist);
    pred_pc = 32'h100;   cycle("R6");
    quiet();
    pred_pc = a_pc;      cycle("R6");
    #1;
    scalar_check("R6 target", pred_target == 32'h0000_5000, pred_target, 32'h5000);
    @(negedge clk);

    // R5: mispredict restores from checkpoint
    for (int i = 0; i < 20; i++) begin
      upd($urandom_range(0, 1023) << 2, 1'($urandom), $urandom & ~32'h3, 1'b1, 6'($urandom));
      pred_pc = $urandom_range(0, 1023) << 2;
      cycle("R5");
    end
    quiet();

    // R9: pop on empty stack returns reset top 0
    ret_valid = 1; cycle("R9"); cycle("R9");
    quiet();

    // R8: overfill then drain
    for (int i = 0; i < 6; i++) begin
      call_valid = 1; call_ret_addr = 32'h0000_A000 + (i << 4);
      pred_pc = 32'h200 + (i << 2);
      cycle("R8");
    end
    call_valid = 0;
    for (int i = 0; i < 4; i++) begin
      ret_valid = 1; cycle("R8");
    end
    // R9: past empty keeps last valid entry
    for (int i = 0; i < 3; i++) begin
      ret_valid = 1; cycle("R9");
    end
    #1;
    scalar_check("R9 top", pred_target == 32'h0000_A020, pred_target, 32'hA020);
    @(negedge clk);

    // R10: call and return together, on empty and non-empty stack
    call_valid = 1; ret_valid = 1; call_ret_addr = 32'h0000_B000; cycle("R10");
    call_valid = 0; ret_valid = 1; cycle("R10");
    call_valid = 1; ret_valid = 0; call_ret_addr = 32'h0000_C000; cycle("R10");
    call_valid = 1; ret_valid = 0; call_ret_addr = 32'h0000_C100; cycle("R10");
    call_valid = 1; ret_valid = 1; call_ret_addr = 32'h0000_C200; cycle("R10");
    call_valid = 0; ret_valid = 1; cycle("R10");
    cycle("R10");
    quiet();

    // R4: random traffic without mispredicts
    for (int i = 0; i < 1500; i++) begin
      pred_pc = $urandom_range(0, 1023) << 2;
      upd_valid = ($urandom_range(0, 1) == 1);
      upd_pc = $urandom_range(0, 1023) << 2;
      upd_taken = 1'($urandom);
      upd_target = $urandom & ~32'h3;
      upd_mispred = 0;
      upd_hist = 6'($urandom);
      call_valid = ($urandom_range(0, 6) == 0);
      call_ret_addr = $urandom & ~32'h3;
      ret_valid = ($urandom_range(0, 6) == 0);
      cycle("R4");
    end

    // R2: full random traffic
    for (int i = 0; i < 3000; i++) begin
      pred_pc = $urandom_range(0, 1023) << 2;
      upd_valid = ($urandom_range(0, 1) == 1);
      upd_pc = $urandom_range(0, 1023) << 2;
      upd_taken = 1'($urandom);
      upd_target = $urandom & ~32'h3;
      upd_mispred = ($urandom_range(0, 3) == 0);
      upd_hist = upd_mispred ? 6'($urandom) : pred_hist;
      call_valid = ($urandom_range(0, 5) == 0);
      call_ret_addr = $urandom & ~32'h3;
      ret_valid = ($urandom_range(0, 5) == 0);
      cycle("R2");
    end
    quiet();
    cycle("R2");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule